// File: doc/BRIEF.md
# Paged Receive Ring Buffer Writer

This block places received Ethernet frames into a circular region of a local byte-wide buffer RAM. The RAM is divided into 256-byte pages, and the ring spans the pages from a programmable first page up to, but not including, a programmable limit page. A frame is announced by a start pulse. The pulse carries the frame's byte count and the verdict of an external address filter. The block then decides, before any byte is written, whether the whole frame fits between the current write page and the host's boundary pointer. A frame that does not fit is consumed and discarded in full.

An accepted frame is written starting at byte 4 of the current page. When it runs past the last page of the ring, it continues at the first page. After the last payload byte, the block fills the four reserved bytes at the start of the frame's first page with a small header: receive status, the page where the next frame will begin, and a two-byte length. It then moves the current page forward and raises a sticky receive-interrupt flag. That flag drives the interrupt line when the receive interrupt enable is set. A host can reload the current-page register while the block is idle.

Top module: `rx_ring_writer`

## Requirements
- R1: While `cfg_stop` is 1, or while `cfg_pstart` is 0, an announced frame is discarded: no RAM write, `cur_page` unchanged, `int_flag` not set.
- R2: The pages a frame needs are (L + 8 + 255) / 256, with integer division, where L is `frm_len`.
- R3: The free page count is bnd − cur when cur < bnd, and (pstop − pstart) − (cur − bnd) otherwise. A frame is discarded with no RAM write when the free count is below the pages needed. A frame that needs exactly the free count is stored.
- R4: The header occupies byte offsets 0, 1, 2, 3 of the frame's first page. It is written in that order, in the four cycles after the last payload byte.
- R5: Header bytes 2 and 3 hold max(L, 60) + 4, low byte first.
- R6: Payload byte i is written at offset 4 + i of the first page, counting on through following pages. The byte after offset 255 of page pstop − 1 goes to offset 0 of page pstart. Cycles with `in_valid` low write nothing.
- R7: Header byte 1 and the new `cur_page` equal cur + pages needed. When that sum is at least pstop, (pstop − pstart) is subtracted from it.
- R8: The status byte (header byte 0 and `rx_status`) has bit 0 set for a stored frame, bit 5 equal to bit 0 of the first payload byte, and every other bit 0.
- R9: `int_flag` rises when a frame's header is complete and stays set until an `int_clr` pulse. `irq` equals `int_flag` AND `cfg_rx_ie`.
- R10: A frame announced with `frm_accept` at 0 is discarded with no RAM write and no state change.
- R11: A `cur_wr` pulse while `busy` is 0 loads `cur_wr_val` into `cur_page`. Reset leaves `cur_page`, `rx_status`, `int_flag`, `irq`, `busy` and `ram_we` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pstart | input | PG_W | First page of the ring |
| cfg_pstop | input | PG_W | Page just past the ring |
| cfg_bnd | input | PG_W | Host boundary page |
| cfg_stop | input | 1 | Receiver halted |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cur_wr | input | 1 | Load pulse for the current page |
| cur_wr_val | input | PG_W | Value for the current page |
| frm_start | input | 1 | Frame announcement pulse |
| frm_len | input | LEN_W | Frame byte count |
| frm_accept | input | 1 | Address filter accepted the frame |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Final payload byte |
| int_clr | input | 1 | Clear pulse for the receive flag |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_addr | output | PG_W+8 | Buffer RAM byte address {page, offset} |
| ram_wdata | output | 8 | Buffer RAM write data |
| cur_page | output | PG_W | Current write page |
| rx_status | output | 8 | Status of the last stored frame |
| int_flag | output | 1 | Sticky frame-received flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Frame in progress |

## Verification
The assertions take several things for granted about the inputs. The ring configuration and the boundary stay unchanged while `busy` is high. The current page always lies inside the ring. The number of payload bytes matches `frm_len` and ends with `in_last`. `frm_start` is pulsed only while `busy` is low. The stimulus respects all of this: configuration changes and current-page reloads happen only between frames, after the bench has waited for `busy` to fall. Every programmed current page lies between the first and limit pages. Each frame's byte stream is generated from the same length that is announced.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_DATA = 2'd1,
      RX_SKIP = 2'd2,
      RX_HDR  = 2'd3
   } rx_state_e;

   localparam int STAT_OK_BIT = 0;
   localparam int STAT_MC_BIT = 5;
   localparam int HDR_BYTES   = 4;
   localparam int CRC_BYTES   = 4;
   localparam int MIN_FRAME   = 60;

   function automatic logic [7:0] rx_stat_byte(input logic mc);
      logic [7:0] s;
      s = 8'h00;
      s[STAT_OK_BIT] = 1'b1;
      s[STAT_MC_BIT] = mc;
      return s;
   endfunction

endpackage

// File: rtl/rxr_space.sv
module rxr_space
   import rxr_pkg::*;
#(
   parameter int PG_W       = 8,
   parameter int LEN_W      = 12,
   parameter bit NEVER_FULL = 1'b0
) (
   input  logic [PG_W-1:0]  pg_start,
   input  logic [PG_W-1:0]  pg_stop,
   input  logic [PG_W-1:0]  bnd,
   input  logic [PG_W-1:0]  cur,
   input  logic [LEN_W-1:0] frm_len,
   output logic             fits,
   output logic [PG_W-1:0]  nxt_page,
   output logic [15:0]      hdr_len
);
   localparam int NW = LEN_W - 6;
   localparam int CW = ((PG_W > NW) ? PG_W : NW) + 1;

   logic [LEN_W+1:0] need_sum;
   logic [NW-1:0]    need;
   logic [CW-1:0]    need_c, cur_c, bnd_c, start_c, stop_c, span_c;
   logic [CW-1:0]    free_c, sum_c, nxt_c;
   logic [LEN_W-1:0] padded;

   always_comb begin
      need_sum = {2'b00, frm_len} + (LEN_W+2)'(HDR_BYTES + CRC_BYTES + 255);
      need     = NW'(need_sum >> 8);
      need_c   = CW'(need);
      cur_c    = CW'(cur);
      bnd_c    = CW'(bnd);
      start_c  = CW'(pg_start);
      stop_c   = CW'(pg_stop);
      span_c   = stop_c - start_c;
      if (cur_c < bnd_c) free_c = bnd_c - cur_c;
      else               free_c = span_c - (cur_c - bnd_c);
      sum_c = cur_c + need_c;
      if (sum_c >= stop_c) nxt_c = sum_c - span_c;
      else                 nxt_c = sum_c;
      nxt_page = PG_W'(nxt_c);
      padded   = (frm_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : frm_len;
      hdr_len  = 16'(padded) + 16'(HDR_BYTES);
   end

   generate
      if (NEVER_FULL) begin : g_strict
         assign fits = (free_c > need_c);
      end else begin : g_exact
         assign fits = (free_c >= need_c);
      end
   endgenerate

endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
   parameter int PG_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PG_W-1:0] load_page,
   input  logic            step,
   input  logic [PG_W-1:0] pg_start,
   input  logic [PG_W-1:0] pg_stop,
   output logic [PG_W+7:0] addr
);
   logic [PG_W-1:0] page_q, page_inc;
   logic [7:0]      off_q;

   assign page_inc = page_q + PG_W'(1);
   assign addr     = {page_q, off_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         off_q  <= 8'd0;
      end else if (load) begin
         page_q <= load_page;
         off_q  <= 8'd4;
      end else if (step) begin
         off_q <= off_q + 8'd1;
         if (off_q == 8'hFF)
            page_q <= (page_inc == pg_stop) ? pg_start : page_inc;
      end
   end

   // payload writes stay inside the ring pages
   assert_wptr_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (page_q >= pg_start && page_q < pg_stop));

endmodule

// File: rtl/rxr_event.sv
module rxr_event
   import rxr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic       mc,
   input  logic       int_clr,
   input  logic       rx_ie,
   output logic [7:0] rx_status,
   output logic       int_flag,
   output logic       irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_status <= 8'h00;
         int_flag  <= 1'b0;
      end else if (done) begin
         rx_status <= rx_stat_byte(mc);
         int_flag  <= 1'b1;
      end else if (int_clr) begin
         int_flag  <= 1'b0;
      end
   end

   assign irq = int_flag & rx_ie;

   assert_flag_follows_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (int_flag && rx_status[STAT_OK_BIT]));

   assert_flag_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> $past(done));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxr_pkg::*;
#(
   parameter int PG_W       = 8,
   parameter int LEN_W      = 12,
   parameter bit NEVER_FULL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PG_W-1:0]  cfg_pstart,
   input  logic [PG_W-1:0]  cfg_pstop,
   input  logic [PG_W-1:0]  cfg_bnd,
   input  logic             cfg_stop,
   input  logic             cfg_rx_ie,
   input  logic             cur_wr,
   input  logic [PG_W-1:0]  cur_wr_val,
   input  logic             frm_start,
   input  logic [LEN_W-1:0] frm_len,
   input  logic             frm_accept,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   input  logic             int_clr,
   output logic             ram_we,
   output logic [PG_W+7:0]  ram_addr,
   output logic [7:0]       ram_wdata,
   output logic [PG_W-1:0]  cur_page,
   output logic [7:0]       rx_status,
   output logic             int_flag,
   output logic             irq,
   output logic             busy
);
   localparam int AW = PG_W + 8;

   generate
      if (PG_W < 1 || PG_W > 8) begin : g_bad_pg
         $error("rx_ring_writer: PG_W must lie in 1..8");
      end
      if (LEN_W < 8 || LEN_W > 16) begin : g_bad_len
         $error("rx_ring_writer: LEN_W must lie in 8..16");
      end
   endgenerate

   rx_state_e       state_q;
   logic [PG_W-1:0] cur_q, nxt_q;
   logic [15:0]     hlen_q;
   logic            mc_q, first_q;
   logic [1:0]      hidx_q;

   logic            fits;
   logic [PG_W-1:0] nxt_page;
   logic [15:0]     hdr_len;
   logic            start_ok, take, step, done;
   logic [AW-1:0]   wp_addr;

   rxr_space #(.PG_W(PG_W), .LEN_W(LEN_W), .NEVER_FULL(NEVER_FULL)) u_space (
      .pg_start (cfg_pstart),
      .pg_stop  (cfg_pstop),
      .bnd      (cfg_bnd),
      .cur      (cur_q),
      .frm_len  (frm_len),
      .fits     (fits),
      .nxt_page (nxt_page),
      .hdr_len  (hdr_len)
   );

   assign take     = (state_q == RX_IDLE) && frm_start;
   assign start_ok = !cfg_stop && (cfg_pstart != '0) && frm_accept && fits;
   assign step     = (state_q == RX_DATA) && in_valid;
   assign done     = (state_q == RX_HDR) && (hidx_q == 2'd3);

   rxr_wptr #(.PG_W(PG_W)) u_wptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (take && start_ok),
      .load_page (cur_q),
      .step      (step),
      .pg_start  (cfg_pstart),
      .pg_stop   (cfg_pstop),
      .addr      (wp_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cur_q   <= '0;
         nxt_q   <= '0;
         hlen_q  <= 16'd0;
         mc_q    <= 1'b0;
         first_q <= 1'b0;
         hidx_q  <= 2'd0;
      end else begin
         case (state_q)
            RX_IDLE: begin
               if (frm_start) begin
                  if (start_ok) begin
                     state_q <= RX_DATA;
                     nxt_q   <= nxt_page;
                     hlen_q  <= hdr_len;
                     first_q <= 1'b1;
                     mc_q    <= 1'b0;
                  end else begin
                     state_q <= RX_SKIP;
                  end
               end else if (cur_wr) begin
                  cur_q <= cur_wr_val;
               end
            end
            RX_DATA: begin
               if (in_valid) begin
                  if (first_q) begin
                     mc_q    <= in_data[0];
                     first_q <= 1'b0;
                  end
                  if (in_last) begin
                     state_q <= RX_HDR;
                     hidx_q  <= 2'd0;
                  end
               end
            end
            RX_SKIP: begin
               if (in_valid && in_last) state_q <= RX_IDLE;
            end
            RX_HDR: begin
               hidx_q <= hidx_q + 2'd1;
               if (hidx_q == 2'd3) begin
                  cur_q   <= nxt_q;
                  state_q <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = wp_addr;
      ram_wdata = in_data;
      if (state_q == RX_DATA) begin
         ram_we = in_valid;
      end else if (state_q == RX_HDR) begin
         ram_we   = 1'b1;
         ram_addr = {cur_q, 6'd0, hidx_q};
         case (hidx_q)
            2'd0:    ram_wdata = rx_stat_byte(mc_q);
            2'd1:    ram_wdata = 8'(nxt_q);
            2'd2:    ram_wdata = hlen_q[7:0];
            default: ram_wdata = hlen_q[15:8];
         endcase
      end
   end

   rxr_event u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .mc        (mc_q),
      .int_clr   (int_clr),
      .rx_ie     (cfg_rx_ie),
      .rx_status (rx_status),
      .int_flag  (int_flag),
      .irq       (irq)
   );

   assign cur_page = cur_q;
   assign busy     = (state_q != RX_IDLE);

   assert_cur_in_ring_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cur_page >= cfg_pstart && cur_page < cfg_pstop));

   assert_flag_after_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_flag) |-> ($past(ram_we) && $past(ram_addr[7:0]) == 8'd3));

   assert_halt_discards_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && frm_start && cfg_stop) |=> (busy && !ram_we));

   assert_write_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy);

endmodule

// File: tb/rx_ring_writer_bench.sv
module rx_ring_writer_bench;
   localparam int PG_W  = 8;
   localparam int LEN_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [PG_W-1:0]  cfg_pstart = '0, cfg_pstop = '0, cfg_bnd = '0;
   logic             cfg_stop = 1'b0, cfg_rx_ie = 1'b0;
   logic             cur_wr = 1'b0;
   logic [PG_W-1:0]  cur_wr_val = '0;
   logic             frm_start = 1'b0, frm_accept = 1'b0;
   logic [LEN_W-1:0] frm_len = '0;
   logic             in_valid = 1'b0, in_last = 1'b0, int_clr = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             ram_we, int_flag, irq, busy;
   logic [PG_W+7:0]  ram_addr;
   logic [7:0]       ram_wdata, rx_status;
   logic [PG_W-1:0]  cur_page;

   rx_ring_writer #(.PG_W(PG_W), .LEN_W(LEN_W)) u_rx_ring_writer (
      .clk(clk), .rst_n(rst_n), .cfg_pstart(cfg_pstart), .cfg_pstop(cfg_pstop),
      .cfg_bnd(cfg_bnd), .cfg_stop(cfg_stop), .cfg_rx_ie(cfg_rx_ie),
      .cur_wr(cur_wr), .cur_wr_val(cur_wr_val), .frm_start(frm_start),
      .frm_len(frm_len), .frm_accept(frm_accept), .in_valid(in_valid),
      .in_data(in_data), .in_last(in_last), .int_clr(int_clr),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .cur_page(cur_page), .rx_status(rx_status), .int_flag(int_flag),
      .irq(irq), .busy(busy));

   always #4 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   logic [23:0] expq[$];
   int          tagq[$];
   int m_cur, m_start, m_stop, m_bnd;
   bit m_halt;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every RAM write is compared with the next expected one
   always @(negedge clk) begin
      if (rst_n && ram_we) begin
         if (expq.size() == 0) begin
            check(1'b0, "R6 unexpected write", {ram_addr, ram_wdata}, 0);
         end else begin
            logic [23:0] e;
            int t;
            e = expq.pop_front();
            t = tagq.pop_front();
            n_checks++;
            if ({ram_addr, ram_wdata} !== e) begin
               n_fail++;
               $display("FAIL R%0d write actual=0x%06h expected=0x%06h", t, {ram_addr, ram_wdata}, e);
            end
         end
      end
   end

   function automatic logic [7:0] pay(input int i, input int len, input logic [7:0] d0);
      return (i == 0) ? d0 : 8'((i * 7 + len) & 255);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_ring(input int st, input int sp, input int bd);
      tick();
      cfg_pstart = PG_W'(st); cfg_pstop = PG_W'(sp); cfg_bnd = PG_W'(bd);
      m_start = st; m_stop = sp; m_bnd = bd;
   endtask

   task automatic load_cur(input int c);
      tick();
      cur_wr = 1'b1; cur_wr_val = PG_W'(c);
      tick();
      cur_wr = 1'b0;
      m_cur = c;
   endtask

   task automatic send_frame(input int len, input logic [7:0] d0, input bit acc,
                             input bit gap, input string tag);
      int need, free, nxt, pg, off, hl;
      bit store;
      int cur_before;
      tick();
      int_clr = 1'b1;
      tick();
      int_clr = 1'b0;
      cur_before = m_cur;
      need = (len + 8 + 255) / 256;                         // R2
      if (m_cur < m_bnd) free = m_bnd - m_cur;              // R3
      else               free = (m_stop - m_start) - (m_cur - m_bnd);
      store = !m_halt && (m_start != 0) && acc && (free >= need);
      nxt = m_cur + need;                                    // R7
      if (nxt >= m_stop) nxt = nxt - (m_stop - m_start);
      hl = ((len < 60) ? 60 : len) + 4;                      // R5
      if (store) begin
         pg = m_cur; off = 4;
         for (int i = 0; i < len; i++) begin
            expq.push_back({8'(pg), 8'(off), pay(i, len, d0)}); tagq.push_back(6);
            off++;
            if (off == 256) begin
               off = 0; pg++;
               if (pg == m_stop) pg = m_start;
            end
         end
         expq.push_back({8'(m_cur), 8'd0, 8'h01 | {2'b00, d0[0], 5'b0}}); tagq.push_back(8);
         expq.push_back({8'(m_cur), 8'd1, 8'(nxt)});    tagq.push_back(7);
         expq.push_back({8'(m_cur), 8'd2, 8'(hl)});     tagq.push_back(5);
         expq.push_back({8'(m_cur), 8'd3, 8'(hl >> 8)}); tagq.push_back(5);
      end
      frm_start = 1'b1; frm_len = LEN_W'(len); frm_accept = acc;
      tick();
      frm_start = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (gap && i == 3) begin
            in_valid = 1'b0;
            tick();
         end
         in_valid = 1'b1; in_data = pay(i, len, d0); in_last = (i == len - 1);
         tick();
      end
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      while (busy) @(negedge clk);
      check(expq.size() == 0, {tag, " all writes seen"}, expq.size(), 0);
      if (store) begin
         m_cur = nxt;
         check(cur_page == PG_W'(nxt), {tag, " R7 cur_page"}, cur_page, nxt);
         check(rx_status == (8'h01 | {2'b00, d0[0], 5'b0}), {tag, " R8 rx_status"},
               rx_status, 8'h01 | {2'b00, d0[0], 5'b0});
         check(int_flag == 1'b1, {tag, " R9 int_flag set"}, int_flag, 1);
      end else begin
         check(cur_page == PG_W'(cur_before), {tag, " cur_page held"}, cur_page, cur_before);
         check(int_flag == 1'b0, {tag, " int_flag untouched"}, int_flag, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      m_halt = 1'b0; m_cur = 0; m_start = 0; m_stop = 0; m_bnd = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      check(ram_we == 1'b0, "R11 reset ram_we", ram_we, 0);
      check(busy == 1'b0, "R11 reset busy", busy, 0);
      check(cur_page == '0, "R11 reset cur_page", cur_page, 0);
      check(rx_status == 8'h00, "R11 reset rx_status", rx_status, 0);
      check(int_flag == 1'b0 && irq == 1'b0, "R11 reset flag/irq", {int_flag, irq}, 0);

      // R1: start page 0 blocks storage
      send_frame(80, 8'h02, 1'b1, 1'b0, "R1 pstart=0");

      set_ring(8'h40, 8'h50, 8'h40);
      load_cur(8'h40);
      @(negedge clk);
      check(cur_page == 8'h40, "R11 cur load", cur_page, 8'h40);

      // R4 R5 R6 R8: unicast frame, one page
      send_frame(100, 8'h02, 1'b1, 1'b0, "R4 unicast");
      // R5: short multicast frame padded to 60 in length field, with a gap
      send_frame(30, 8'h01, 1'b1, 1'b1, "R5 short multicast");
      // R2: three-page frame
      send_frame(600, 8'h33, 1'b1, 1'b0, "R2 three pages");

      // R1: halted receiver
      tick(); cfg_stop = 1'b1; m_halt = 1'b1;
      send_frame(70, 8'h02, 1'b1, 1'b0, "R1 halted");
      tick(); cfg_stop = 1'b0; m_halt = 1'b0;

      // R10: filter rejection
      send_frame(70, 8'h02, 1'b0, 1'b0, "R10 rejected");

      // R3: one free page, two needed -> dropped; then one needed -> stored
      set_ring(8'h40, 8'h50, 8'h46);
      send_frame(300, 8'h04, 1'b1, 1'b0, "R3 no room");
      send_frame(100, 8'h06, 1'b1, 1'b0, "R3 exact fit");

      // R6 R7: payload and next page wrap at the ring end
      set_ring(8'h40, 8'h50, 8'h48);
      load_cur(8'h4F);
      send_frame(400, 8'h09, 1'b1, 1'b0, "R6 wrap");

      // R9: interrupt gating and clearing
      tick(); cfg_rx_ie = 1'b0;
      @(negedge clk);
      check(irq == 1'b0 && int_flag == 1'b1, "R9 irq masked", {int_flag, irq}, 2);
      tick(); cfg_rx_ie = 1'b1;
      @(negedge clk);
      check(irq == 1'b1, "R9 irq enabled", irq, 1);
      tick(); int_clr = 1'b1;
      tick(); int_clr = 1'b0;
      @(negedge clk);
      check(int_flag == 1'b0 && irq == 1'b0, "R9 clear", {int_flag, irq}, 0);

      repeat (4) @(posedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule